// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block generates one active-low interrupt for each side of a two-sided shared memory. The two highest addresses of the memory serve as mailboxes: the very top word belongs to the right side and the word just below it belongs to the left side. When one side writes into the other side's mailbox, the other side's interrupt goes active. The receiving side releases its own interrupt by accessing its mailbox with chip enable and output enable both low. The level of its read/write line plays no part in that release.

The block only watches each side's control bus: chip enable, output enable, read/write, a 15-bit address, and a busy input from the collision arbiter. It drives the two interrupt lines and nothing else. The mailbox words remain ordinary storage in the memory array, which sits outside this block. Any side whose busy input is low is treated as if it made no access at all. Both outputs are registered and driven high and low actively, and each changes on the clock edge that samples the qualifying access.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While synchronous reset is low, and on the first edge after it is released with idle inputs, both interrupt outputs read 1 (inactive).
- R2: When the left side makes a write (l_cs_n=0, l_we_n=0) to address 0x7FFF with l_busy_n=1, r_irq_n is 0 after the next rising clock edge.
- R3: When the right side has r_cs_n=0 and r_oe_n=0 at address 0x7FFF with r_busy_n=1, r_irq_n is 1 after the next edge, for either level of r_we_n.
- R4: When the right side makes a write (r_cs_n=0, r_we_n=0) to address 0x7FFE with r_busy_n=1, l_irq_n is 0 after the next edge.
- R5: When the left side has l_cs_n=0 and l_oe_n=0 at address 0x7FFE with l_busy_n=1, l_irq_n is 1 after the next edge, for either level of l_we_n.
- R6: A side whose busy input is 0 neither sets nor clears any interrupt in that cycle.
- R7: If the same interrupt is set and cleared in the same cycle, it is 0 (set) after the edge.
- R8: In any cycle with no qualifying set or clear, for example chip enable high, another address, a read to the partner's mailbox, or a write to one's own mailbox with output enable high, each interrupt keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_cs_n | input | 1 | Left chip enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left read/write, 0 = write |
| l_addr | input | 15 | Left address |
| l_busy_n | input | 1 | Left busy from arbiter, 0 = held off |
| r_cs_n | input | 1 | Right chip enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right read/write, 0 = write |
| r_addr | input | 15 | Right address |
| r_busy_n | input | 1 | Right busy from arbiter, 0 = held off |
| l_irq_n | output | 1 | Left interrupt, active low, driven both ways |
| r_irq_n | output | 1 | Right interrupt, active low, driven both ways |

## Verification
The bench targets the following corner cases:
- A clear made with the read/write line low. A design that decodes a true read would leave the interrupt set.
- A busy-held side that writes to or reads its mailbox. A design that ignores busy would change the flag.
- A set and a clear in the same cycle. A design that gives the clear priority would lose a message notification.
- Near-miss addresses, such as the partner's mailbox read back and each side writing its own mailbox. A design with loose decoding would move the wrong flag.

Random traffic biased toward the two mailbox words covers interleavings of all of these.

// File: rtl/mbox_pkg.sv
// Package: shared constants and helpers for the mailbox interrupt block.
// Assumes two sides only, indexed left = 0 and right = 1.
package mbox_pkg;
    localparam int unsigned MBOX_ADDR_W = 15;
    localparam int unsigned NUM_SIDES   = 2;

    typedef enum logic {SIDE_LEFT = 1'b0, SIDE_RIGHT = 1'b1} side_e;

    // Mailbox word owned by a side: right owns the top word, left the one below.
    function automatic logic [MBOX_ADDR_W-1:0] own_box(input int unsigned side);
        logic [MBOX_ADDR_W-1:0] top;
        top = '1;
        return (side == 0) ? top - 1'b1 : top;
    endfunction

    // Index of the opposite side.
    function automatic int unsigned peer_of(input int unsigned side);
        return (side == 0) ? 1 : 0;
    endfunction
endpackage

// File: rtl/mbox_access_decode.sv
// Module: mbox_access_decode
// Decodes one side's control bus into two strobes: a post to the peer's
// mailbox (a write) and a take of its own mailbox (cs and oe low, any r/w).
// Assumes active-low controls. A side held busy produces neither strobe.
module mbox_access_decode #(
    parameter int unsigned ADDR_W = 15,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_n,
    output logic              post_o,
    output logic              take_o
);
    logic sel;

    // Purpose: combinational strobe decode, gated by chip enable and busy.
    always_comb begin
        sel    = !cs_n && busy_n;
        post_o = sel && !we_n && (addr == PEER_BOX);
        take_o = sel && !oe_n && (addr == OWN_BOX);
    end

    // R6
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |-> (!post_o && !take_o));
    // R8
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!post_o && !take_o));
endmodule

// File: rtl/mbox_flag_reg.sv
// Module: mbox_flag_reg
// Holds one active-low interrupt flag. A set drives it low, a clear drives
// it high, and a set wins when both arrive in the same cycle. The output
// comes straight from the flop and is driven both ways.
module mbox_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);
    // Purpose: update the flag on each edge with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_n_o <= 1'b1;
        else if (set_i)  irq_n_o <= 1'b0;
        else if (clr_i)  irq_n_o <= 1'b1;
    end

    // R2 R4 R7
    set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> !irq_n_o);
    // R3 R5
    clear_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> irq_n_o);
    // R8
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(irq_n_o));
endmodule

// File: rtl/mbox_irq_ctrl.sv
// Module: mbox_irq_ctrl (top)
// Mailbox interrupt logic for a two-sided memory. Each side gets a decoder.
// The peer's post strobe and the own side's take strobe feed that side's flag.
// Assumes both buses are synchronous to clk. The memory array and the
// arbitration that produces busy live elsewhere.
module mbox_irq_ctrl #(
    parameter int unsigned ADDR_W = mbox_pkg::MBOX_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs_n,
    input  logic              l_oe_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy_n,
    input  logic              r_cs_n,
    input  logic              r_oe_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy_n,
    output logic              l_irq_n,
    output logic              r_irq_n
);
    import mbox_pkg::*;
    localparam int unsigned NS = NUM_SIDES;
    localparam logic [ADDR_W-1:0] TOP_WORD = '1;

    logic              cs_v   [NS];
    logic              oe_v   [NS];
    logic              we_v   [NS];
    logic [ADDR_W-1:0] addr_v [NS];
    logic              busy_v [NS];
    logic              post_v [NS];
    logic              take_v [NS];
    logic              irq_v  [NS];

    // Purpose: gather the side buses into arrays indexed by side.
    always_comb begin
        cs_v[SIDE_LEFT]    = l_cs_n;   cs_v[SIDE_RIGHT]   = r_cs_n;
        oe_v[SIDE_LEFT]    = l_oe_n;   oe_v[SIDE_RIGHT]   = r_oe_n;
        we_v[SIDE_LEFT]    = l_we_n;   we_v[SIDE_RIGHT]   = r_we_n;
        addr_v[SIDE_LEFT]  = l_addr;   addr_v[SIDE_RIGHT] = r_addr;
        busy_v[SIDE_LEFT]  = l_busy_n; busy_v[SIDE_RIGHT] = r_busy_n;
    end

    for (genvar s = 0; s < NS; s++) begin : g_side
        localparam logic [ADDR_W-1:0] OWN  = (s == 0) ? TOP_WORD - 1'b1 : TOP_WORD;
        localparam logic [ADDR_W-1:0] PEER = (s == 0) ? TOP_WORD : TOP_WORD - 1'b1;
        localparam int unsigned       PS   = (s == 0) ? 1 : 0;

        mbox_access_decode #(.ADDR_W(ADDR_W), .OWN_BOX(OWN), .PEER_BOX(PEER)) u_dec (
            .clk    (clk),
            .rst_n  (rst_n),
            .cs_n   (cs_v[s]),
            .oe_n   (oe_v[s]),
            .we_n   (we_v[s]),
            .addr   (addr_v[s]),
            .busy_n (busy_v[s]),
            .post_o (post_v[s]),
            .take_o (take_v[s])
        );

        mbox_flag_reg u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (post_v[PS]),
            .clr_i   (take_v[s]),
            .irq_n_o (irq_v[s])
        );
    end

    assign l_irq_n = irq_v[SIDE_LEFT];
    assign r_irq_n = irq_v[SIDE_RIGHT];

    // R6: a busy right side cannot raise the left interrupt.
    busy_right_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_busy_n && l_irq_n && (l_cs_n || l_oe_n)) |=> l_irq_n);
    // R6: a busy left side cannot raise the right interrupt.
    busy_left_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n && r_irq_n && (r_cs_n || r_oe_n)) |=> r_irq_n);
endmodule

// File: tb/sim_mbox_irq_ctrl.sv
module sim_mbox_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 15;
    localparam logic [AW-1:0] BOX_R = 15'h7FFF;
    localparam logic [AW-1:0] BOX_L = 15'h7FFE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_cs_n = 1, l_oe_n = 1, l_we_n = 1, l_busy_n = 1;
    logic r_cs_n = 1, r_oe_n = 1, r_we_n = 1, r_busy_n = 1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;
    int n_cmp = 0, n_bad = 0;
    logic exp_l = 1'b1, exp_r = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
        .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    // Next value of an active-low flag: set wins over clear.
    function automatic logic next_flag(input logic cur, input logic set, input logic clr);
        return set ? 1'b0 : (clr ? 1'b1 : cur);
    endfunction

    // Requirement tag for the event that drives one flag this cycle.
    function automatic string tag_of(input logic set, input logic clr, input logic blocked,
                                     input string set_tag, input string clr_tag);
        if (set && clr) return "R7";
        if (set) return set_tag;
        if (clr) return clr_tag;
        if (blocked) return "R6";
        return "R8";
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus at negedge and check both flags at the next negedge.
    task automatic step(input logic lc, lo, lw, input logic [AW-1:0] la, input logic lb,
                        input logic rc, ro, rw, input logic [AW-1:0] ra, input logic rb,
                        input string force_tag);
        logic set_r, clr_r, set_l, clr_l, blk_r, blk_l;
        string tr, tl;
        l_cs_n = lc; l_oe_n = lo; l_we_n = lw; l_addr = la; l_busy_n = lb;
        r_cs_n = rc; r_oe_n = ro; r_we_n = rw; r_addr = ra; r_busy_n = rb;
        set_r = !lc && !lw && la == BOX_R && lb;
        clr_r = !rc && !ro && ra == BOX_R && rb;
        set_l = !rc && !rw && ra == BOX_L && rb;
        clr_l = !lc && !lo && la == BOX_L && lb;
        blk_r = (!lb && !lc && la == BOX_R) || (!rb && !rc && ra == BOX_R);
        blk_l = (!rb && !rc && ra == BOX_L) || (!lb && !lc && la == BOX_L);
        tr = (force_tag != "") ? force_tag : tag_of(set_r, clr_r, blk_r, "R2", "R3");
        tl = (force_tag != "") ? force_tag : tag_of(set_l, clr_l, blk_l, "R4", "R5");
        exp_r = next_flag(exp_r, set_r, clr_r);
        exp_l = next_flag(exp_l, set_l, clr_l);
        @(posedge clk);
        @(negedge clk);
        check(tr, "r_irq_n", r_irq_n, exp_r);
        check(tl, "l_irq_n", l_irq_n, exp_l);
    endtask

    task automatic idle();
        step(1,1,1,'0,1, 1,1,1,'0,1, "");
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1", "l_irq_n in reset", l_irq_n, 1'b1);
        check("R1", "r_irq_n in reset", r_irq_n, 1'b1);
        rst_n = 1'b1;
        step(1,1,1,'0,1, 1,1,1,'0,1, "R1");

        // R2 set right, R3 clear with r/w high
        step(0,1,0,BOX_R,1, 1,1,1,'0,1, "");
        step(1,1,1,'0,1, 0,0,1,BOX_R,1, "");
        // R3 clear with r/w low (write into own box)
        step(0,1,0,BOX_R,1, 1,1,1,'0,1, "");
        step(1,1,1,'0,1, 0,0,0,BOX_R,1, "");
        // R4 / R5
        step(1,1,1,'0,1, 0,1,0,BOX_L,1, "");
        step(0,0,0,BOX_L,1, 1,1,1,'0,1, "");
        // R6 busy left blocks set of right
        step(0,1,0,BOX_R,0, 1,1,1,'0,1, "R6");
        // R6 busy right blocks its clear
        step(0,1,0,BOX_R,1, 1,1,1,'0,1, "");
        step(1,1,1,'0,1, 0,0,1,BOX_R,0, "R6");
        // R7 set and clear of right together
        step(0,1,0,BOX_R,1, 0,0,1,BOX_R,1, "R7");
        step(1,1,1,'0,1, 0,0,1,BOX_R,1, "");
        // R8 near misses: cs high, other address, own-box write with oe high, peer box read
        step(1,1,0,BOX_R,1, 1,1,0,BOX_L,1, "R8");
        step(0,1,0,15'h7FFD,1, 0,0,0,15'h0FFF,1, "R8");
        step(0,1,0,BOX_L,1, 0,1,0,BOX_R,1, "R8");
        step(0,0,1,BOX_R,1, 0,0,1,BOX_L,1, "R8");
        idle();

        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] la, ra;
            int unsigned k;
            k = $urandom_range(0, 3);
            la = (k == 0) ? BOX_L : (k == 1) ? BOX_R : (k == 2) ? 15'($urandom) : BOX_R - 15'd2;
            k = $urandom_range(0, 3);
            ra = (k == 0) ? BOX_L : (k == 1) ? BOX_R : (k == 2) ? 15'($urandom) : BOX_L - 15'd1;
            step(1'($urandom), 1'($urandom), 1'($urandom), la, ($urandom_range(0,4) != 0),
                 1'($urandom), 1'($urandom), 1'($urandom), ra, ($urandom_range(0,4) != 0), "");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule